// File: doc/BRIEF.md
# Capability Tag Rule Enforcer

This block sits between operand fetch, the ALU and the memory access stage of a processor in which every register and every memory word carries one extra tag bit. The bit tells whether the word is a capability (an unforgeable segment address) or plain data. For every operation presented to it, the block applies fixed tag rules. A copy passes the source tag through unchanged. Arithmetic and logic accept only data operands and always yield data. An addressing operation demands a capability as its segment operand. Setting the tag to capability is allowed only in privileged mode. When the rules are met, the block either produces a result word with its tag or issues a memory request. When they are broken, it raises a two-bit fault code, and it then neither writes a result nor issues a request.

Each presented operation is resolved one clock later. A four-state outcome register (IDLE, WRITE, MEMREQ, FAULT) selects which of the output groups is live in that cycle. The next-state choice is made fresh for every operation: no operation → IDLE; any rule broken → FAULT; an addressing class with a capability segment → MEMREQ; otherwise → WRITE. Every state can move to every other state on the next clock.

Top module: `tagchk_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, res_valid, mem_req and mem_we are 0 and fault_code is 2'b00.
- R2: MOVE (op_class 3'd0) gives res_valid=1, res_value=src_a and res_tag=tag_a in the next cycle, whatever the tags and addr_tag are.
- R3: ADD (3'd1, sum modulo 2^W), AND (3'd2), OR (3'd3) and XOR (3'd4) with tag_a=0 and tag_b=0 give res_valid=1, the computed value and res_tag=0 in the next cycle.
- R4: ADD, AND, OR or XOR with tag_a=1 or tag_b=1 gives fault_code=2'b01 and res_valid=0 in the next cycle.
- R5: LOAD (3'd5) or STORE (3'd6) with addr_tag=0 gives fault_code=2'b10 and mem_req=0 in the next cycle, even if the stored word is a capability.
- R6: LOAD with addr_tag=1 gives mem_req=1, mem_we=0, mem_offset=src_b and res_valid=0 in the next cycle. The operand tags play no part.
- R7: STORE with addr_tag=1 gives mem_req=1, mem_we=1, mem_offset=src_b, mem_wdata=src_a and mem_wtag=tag_a in the next cycle.
- R8: SETCAP (3'd7) with priv=1 gives res_valid=1, res_value=src_a and res_tag=1 in the next cycle. With priv=0 it gives fault_code=2'b11 and res_valid=0.
- R9: A cycle with op_valid=0 gives no result, no request and fault_code=2'b00 in the next cycle. Value outputs read zero whenever their qualifying strobe is low: res_value and res_tag with res_valid, mem_offset with mem_req, mem_wdata and mem_wtag with mem_we.
- R10: In any cycle at most one of res_valid, mem_req and a non-zero fault_code is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_class | input | 3 | Operation class code (see R2 to R8) |
| src_a | input | W | First operand value |
| tag_a | input | 1 | First operand tag, 1 means capability |
| src_b | input | W | Second operand value, offset for addressing |
| tag_b | input | 1 | Second operand tag |
| addr_tag | input | 1 | Tag of the segment-address operand |
| priv | input | 1 | Privileged mode |
| res_valid | output | 1 | Destination write strobe |
| res_value | output | W | Destination value |
| res_tag | output | 1 | Destination tag |
| mem_req | output | 1 | Memory request issued |
| mem_we | output | 1 | Request is a store |
| mem_offset | output | W | Word offset within the segment |
| mem_wdata | output | W | Store data |
| mem_wtag | output | 1 | Store tag |
| fault_code | output | 2 | 00 none, 01 illegal operand, 10 address not capability, 11 illegal tag set |

## Verification
Two rules can apply in the same cycle. On a STORE, the stored word's tag must be copied, and the segment operand must be checked. The bench presents a STORE whose data word is a capability while addr_tag is 0. The expected result is fault 10 with no request and a zeroed store tag, because the address fault must suppress the tag copy. In the same way, SETCAP on a source already tagged as a capability is judged on priv alone. After the directed cases, random traffic runs with all tag combinations, and the outputs are compared every clock against a behavioural model.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;

    typedef enum logic [2:0] {
        OPC_MOVE   = 3'd0,
        OPC_ADD    = 3'd1,
        OPC_AND    = 3'd2,
        OPC_OR     = 3'd3,
        OPC_XOR    = 3'd4,
        OPC_LOAD   = 3'd5,
        OPC_STORE  = 3'd6,
        OPC_SETCAP = 3'd7
    } opc_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_OPERAND = 2'b01,
        FLT_ADDRESS = 2'b10,
        FLT_TAGSET  = 2'b11
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_MEMREQ,
        ST_FAULT
    } st_e;

    typedef struct packed {
        logic is_move;
        logic is_arith;
        logic is_addr;
        logic is_store;
        logic is_setcap;
    } dec_t;

endpackage

// File: rtl/tagchk_decode.sv
module tagchk_decode
    import tagchk_pkg::*;
(
    input  logic [2:0] op_class,
    output dec_t       dec
);
    opc_e opc;

    always_comb begin
        opc = opc_e'(op_class);
        dec = '0;
        unique case (opc)
            OPC_MOVE:                          dec.is_move   = 1'b1;
            OPC_ADD, OPC_AND, OPC_OR, OPC_XOR: dec.is_arith  = 1'b1;
            OPC_LOAD:                          dec.is_addr   = 1'b1;
            OPC_STORE: begin
                dec.is_addr  = 1'b1;
                dec.is_store = 1'b1;
            end
            OPC_SETCAP:                        dec.is_setcap = 1'b1;
            default:                           dec = '0;
        endcase
    end
endmodule

// File: rtl/tagchk_rules.sv
module tagchk_rules
    import tagchk_pkg::*;
(
    input  dec_t dec,
    input  logic tag_a,
    input  logic tag_b,
    input  logic addr_tag,
    input  logic priv,
    output flt_e fault,
    output logic dst_tag
);
    // Fault selection: the addressing check outranks everything else.
    always_comb begin
        fault = FLT_NONE;
        if (dec.is_addr && !addr_tag)
            fault = FLT_ADDRESS;
        else if (dec.is_arith && (tag_a || tag_b))
            fault = FLT_OPERAND;
        else if (dec.is_setcap && !priv)
            fault = FLT_TAGSET;
    end

    // Tag propagation: copies keep the source tag, SETCAP forces a capability,
    // and every other class yields data.
    always_comb begin
        if (dec.is_setcap)
            dst_tag = 1'b1;
        else if (dec.is_move || dec.is_store)
            dst_tag = tag_a;
        else
            dst_tag = 1'b0;
    end
endmodule

// File: rtl/tagchk_alu.sv
module tagchk_alu
    import tagchk_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   op_class,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    opc_e         opc;
    logic [W-1:0] bitwise;

    assign opc = opc_e'(op_class);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (opc)
                OPC_AND: bitwise[i] = a[i] & b[i];
                OPC_OR:  bitwise[i] = a[i] | b[i];
                OPC_XOR: bitwise[i] = a[i] ^ b[i];
                default: bitwise[i] = a[i];
            endcase
        end
    end

    assign y = (opc == OPC_ADD) ? (a + b) : bitwise;
endmodule

// File: rtl/tagchk_unit.sv
module tagchk_unit
    import tagchk_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [2:0]   op_class,
    input  logic [W-1:0] src_a,
    input  logic         tag_a,
    input  logic [W-1:0] src_b,
    input  logic         tag_b,
    input  logic         addr_tag,
    input  logic         priv,
    output logic         res_valid,
    output logic [W-1:0] res_value,
    output logic         res_tag,
    output logic         mem_req,
    output logic         mem_we,
    output logic [W-1:0] mem_offset,
    output logic [W-1:0] mem_wdata,
    output logic         mem_wtag,
    output logic [1:0]   fault_code
);
    dec_t         dec;
    flt_e         fault;
    logic         dst_tag;
    logic [W-1:0] alu_y;

    st_e          state_q, state_d;
    logic [W-1:0] val_q;
    logic [W-1:0] off_q;
    logic         tag_q;
    logic         we_q;
    flt_e         flt_q;

    tagchk_decode u_decode (
        .op_class (op_class),
        .dec      (dec)
    );

    tagchk_rules u_rules (
        .dec      (dec),
        .tag_a    (tag_a),
        .tag_b    (tag_b),
        .addr_tag (addr_tag),
        .priv     (priv),
        .fault    (fault),
        .dst_tag  (dst_tag)
    );

    tagchk_alu #(.W(W)) u_alu (
        .op_class (op_class),
        .a        (src_a),
        .b        (src_b),
        .y        (alu_y)
    );

    // Next outcome, chosen afresh for each presented operation.
    always_comb begin
        if (!op_valid)
            state_d = ST_IDLE;
        else if (fault != FLT_NONE)
            state_d = ST_FAULT;
        else if (dec.is_addr)
            state_d = ST_MEMREQ;
        else
            state_d = ST_WRITE;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Output payload register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
            off_q <= '0;
            tag_q <= 1'b0;
            we_q  <= 1'b0;
            flt_q <= FLT_NONE;
        end else begin
            val_q <= alu_y;
            off_q <= src_b;
            tag_q <= dst_tag;
            we_q  <= dec.is_store;
            flt_q <= op_valid ? fault : FLT_NONE;
        end
    end

    // Outputs gated by the outcome state.
    always_comb begin
        res_valid  = 1'b0;
        res_value  = '0;
        res_tag    = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_offset = '0;
        mem_wdata  = '0;
        mem_wtag   = 1'b0;
        fault_code = FLT_NONE;
        unique case (state_q)
            ST_IDLE: ;
            ST_WRITE: begin
                res_valid = 1'b1;
                res_value = val_q;
                res_tag   = tag_q;
            end
            ST_MEMREQ: begin
                mem_req    = 1'b1;
                mem_offset = off_q;
                if (we_q) begin
                    mem_we    = 1'b1;
                    mem_wdata = val_q;
                    mem_wtag  = tag_q;
                end
            end
            ST_FAULT:  fault_code = flt_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/tagchk_sva.sv
module tagchk_sva #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [2:0]   op_class,
    input logic [W-1:0] src_a,
    input logic         tag_a,
    input logic         tag_b,
    input logic         addr_tag,
    input logic         priv,
    input logic         res_valid,
    input logic [W-1:0] res_value,
    input logic         res_tag,
    input logic         mem_req,
    input logic         mem_we,
    input logic         mem_wtag,
    input logic [1:0]   fault_code
);
    logic arith_in;
    logic addr_in;
    assign arith_in = (op_class >= 3'd1) && (op_class <= 3'd4);
    assign addr_in  = (op_class == 3'd5) || (op_class == 3'd6);

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_valid, mem_req, fault_code != 2'b00}));

    p_move_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == 3'd0) |=>
            (res_valid && res_tag == $past(tag_a) && res_value == $past(src_a)));

    p_arith_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && arith_in && !tag_a && !tag_b) |=> (res_valid && !res_tag));

    p_arith_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && arith_in && (tag_a || tag_b)) |=> (fault_code == 2'b01 && !res_valid));

    p_addr_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && addr_in && !addr_tag) |=> (fault_code == 2'b10 && !mem_req));

    p_load_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == 3'd5 && addr_tag) |=> (mem_req && !mem_we));

    p_store_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == 3'd6 && addr_tag) |=> (mem_we && mem_wtag == $past(tag_a)));

    p_setcap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == 3'd7) |=>
            ($past(priv) ? (res_valid && res_tag) : (fault_code == 2'b11)));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !mem_req && fault_code == 2'b00));
endmodule

bind tagchk_unit tagchk_sva #(.W(W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_class   (op_class),
    .src_a      (src_a),
    .tag_a      (tag_a),
    .tag_b      (tag_b),
    .addr_tag   (addr_tag),
    .priv       (priv),
    .res_valid  (res_valid),
    .res_value  (res_value),
    .res_tag    (res_tag),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_wtag   (mem_wtag),
    .fault_code (fault_code)
);

// File: tb/test_tagchk_unit.sv
`timescale 1ns/1ps
module test_tagchk_unit;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [2:0]   op_class = '0;
    logic [W-1:0] src_a = '0;
    logic         tag_a = 1'b0;
    logic [W-1:0] src_b = '0;
    logic         tag_b = 1'b0;
    logic         addr_tag = 1'b0;
    logic         priv = 1'b0;
    logic         res_valid;
    logic [W-1:0] res_value;
    logic         res_tag;
    logic         mem_req;
    logic         mem_we;
    logic [W-1:0] mem_offset;
    logic [W-1:0] mem_wdata;
    logic         mem_wtag;
    logic [1:0]   fault_code;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Expected outputs for the coming cycle.
    logic         e_rv, e_rt, e_mr, e_mw, e_wt;
    logic [W-1:0] e_val, e_off, e_wd;
    logic [1:0]   e_flt;
    string        e_req;

    always #2 clk = ~clk;

    tagchk_unit #(.W(W)) i_tagchk_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
        .src_a(src_a), .tag_a(tag_a), .src_b(src_b), .tag_b(tag_b),
        .addr_tag(addr_tag), .priv(priv), .res_valid(res_valid),
        .res_value(res_value), .res_tag(res_tag), .mem_req(mem_req),
        .mem_we(mem_we), .mem_offset(mem_offset), .mem_wdata(mem_wdata),
        .mem_wtag(mem_wtag), .fault_code(fault_code)
    );

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_exp(input string req);
        e_rv = 0; e_rt = 0; e_mr = 0; e_mw = 0; e_wt = 0;
        e_val = '0; e_off = '0; e_wd = '0; e_flt = 2'b00; e_req = req;
    endtask

    // Behavioural model of the rules, from the requirements.
    task automatic model();
        int oc;
        oc = int'(op_class);
        clear_exp("R9");
        if (!op_valid) return;
        if (oc == 0) begin
            e_req = "R2"; e_rv = 1; e_val = src_a; e_rt = tag_a;
        end else if (oc >= 1 && oc <= 4) begin
            if (tag_a || tag_b) begin
                e_req = "R4"; e_flt = 2'b01;
            end else begin
                e_req = "R3"; e_rv = 1; e_rt = 0;
                case (oc)
                    1: e_val = src_a + src_b;
                    2: e_val = src_a & src_b;
                    3: e_val = src_a | src_b;
                    default: e_val = src_a ^ src_b;
                endcase
            end
        end else if (oc == 5 || oc == 6) begin
            if (!addr_tag) begin
                e_req = "R5"; e_flt = 2'b10;
            end else begin
                e_req = (oc == 5) ? "R6" : "R7";
                e_mr = 1; e_off = src_b;
                if (oc == 6) begin
                    e_mw = 1; e_wd = src_a; e_wt = tag_a;
                end
            end
        end else begin
            if (priv) begin
                e_req = "R8"; e_rv = 1; e_val = src_a; e_rt = 1;
            end else begin
                e_req = "R8"; e_flt = 2'b11;
            end
        end
    endtask

    task automatic compare_all();
        chk(e_req, "res_valid", W'(res_valid), W'(e_rv));
        chk(e_req, "res_value", res_value, e_val);
        chk(e_req, "res_tag", W'(res_tag), W'(e_rt));
        chk(e_req, "mem_req", W'(mem_req), W'(e_mr));
        chk(e_req, "mem_we", W'(mem_we), W'(e_mw));
        chk(e_req, "mem_offset", mem_offset, e_off);
        chk(e_req, "mem_wdata", mem_wdata, e_wd);
        chk(e_req, "mem_wtag", W'(mem_wtag), W'(e_wt));
        chk(e_req, "fault_code", W'(fault_code), W'(e_flt));
        // R10: a single outcome per cycle
        chk("R10", "outcome_count",
            W'(int'(res_valid) + int'(mem_req) + int'(fault_code != 2'b00)),
            W'((res_valid || mem_req || fault_code != 2'b00) ? 1 : 0));
    endtask

    // One clock step: check what the previous inputs produced, then drive new ones.
    task automatic step(input logic v, input logic [2:0] oc,
                        input logic [W-1:0] a, input logic ta,
                        input logic [W-1:0] b, input logic tb,
                        input logic at, input logic pv);
        @(negedge clk);
        compare_all();
        op_valid = v; op_class = oc; src_a = a; tag_a = ta;
        src_b = b; tag_b = tb; addr_tag = at; priv = pv;
        model();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet while in reset
        clear_exp("R1");
        compare_all();
        rst_n = 1'b1;
        clear_exp("R1");
        // R2: move keeps a capability tag, addr_tag ignored
        step(1, 3'd0, 32'hCAFE_0001, 1, 32'h5, 0, 0, 0);
        step(1, 3'd0, 32'h1234_5678, 0, 32'h0, 1, 1, 1);
        // R3: arithmetic and logic on data
        step(1, 3'd1, 32'hFFFF_FFFF, 0, 32'h2, 0, 1, 0);
        step(1, 3'd2, 32'hF0F0_1234, 0, 32'h0FF0_FF00, 0, 0, 0);
        step(1, 3'd3, 32'hF000_0000, 0, 32'h0000_000F, 0, 0, 1);
        step(1, 3'd4, 32'hAAAA_5555, 0, 32'hFFFF_0000, 0, 0, 0);
        // R4: capability operands refused, also when privileged
        step(1, 3'd1, 32'h1, 1, 32'h1, 0, 1, 1);
        step(1, 3'd4, 32'h1, 0, 32'h1, 1, 1, 0);
        // R5: data segment operand, including a capability store
        step(1, 3'd6, 32'hDEAD_BEEF, 1, 32'h40, 0, 0, 1);
        step(1, 3'd5, 32'h0, 0, 32'h44, 0, 0, 0);
        // R6/R7: valid addressing
        step(1, 3'd5, 32'h9, 1, 32'h80, 1, 1, 0);
        step(1, 3'd6, 32'hBEEF_0000, 1, 32'h84, 0, 1, 0);
        step(1, 3'd6, 32'h0000_BEEF, 0, 32'h88, 1, 1, 0);
        // R8: privileged tag set, also on a capability source, and refused otherwise
        step(1, 3'd7, 32'h7777, 0, 32'h0, 0, 0, 1);
        step(1, 3'd7, 32'h8888, 1, 32'h0, 0, 1, 1);
        step(1, 3'd7, 32'h9999, 0, 32'h0, 0, 1, 0);
        // R9: idle with live-looking operands
        step(0, 3'd6, 32'h1111, 1, 32'h2222, 1, 1, 1);
        step(0, 3'd0, 32'h3333, 1, 32'h4444, 0, 0, 0);
        // Random traffic
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 8) != 0, 3'($urandom), 32'($urandom),
                 1'($urandom), 32'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom));
        end
        step(0, 3'd0, '0, 0, '0, 0, 0, 0);
        @(negedge clk);
        compare_all();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule